// File: doc/BRIEF.md
# Single-Cycle Three-Format RISC Core

This block is a small 32-bit processor core. It executes one instruction per clock from a fixed-width, three-format encoding: register format, immediate format and jump format. Each cycle it fetches the word at the program counter, decodes it, reads up to two operands from a 32 × 32-bit register file, computes a result, and then writes a register, a data word in memory, or the program counter. Register 0 always reads as zero. A subroutine call stores its return address in register 31. A full 32-bit constant takes two instructions: one loads the upper half and one fills the lower half.

The core has a combinational word-wide fetch port and a data port. The data port has address, write data, write enable and read data. Both memories live outside the block, and both must return read data in the same cycle the address is presented. The active-low reset is asserted asynchronously and released through a short synchronizer. From reset the program counter starts at a parameterized address. Instructions the core does not recognize write nothing and fall through to the next word.

Top module: `tri_fmt_core`

## Requirements
- R1: While reset is asserted, and until the first fetch after release, the fetch address equals RESET_PC (default 0) and the data write enable is low.
- R2: Register-format instructions (op 000000) with funct 100000 write rs+rt to rd, and with funct 100010 write rs−rt to rd, both modulo 2^32.
- R3: Register-format funct 100100 writes rs AND rt to rd, funct 100101 writes rs OR rt, and funct 100111 writes NOT(rs OR rt).
- R4: Register-format funct 000000 writes rt shifted left by shamt (bits 10:6) to rd, and funct 000010 shifts rt right logically. Both fill vacated bits with zeros.
- R5: funct 101010 writes 1 to rd when rs < rt as signed values, else 0. slti (op 001010) does the same into rt against the sign-extended 16-bit immediate.
- R6: addi (op 001000) writes rs + sign-extended immediate to rt. ori (op 001101) writes rs OR zero-extended immediate to rt. lui (op 001111) writes {imm, 16'h0000} to rt.
- R7: Register 0 reads as zero, and any write aimed at it, including a load, is discarded.
- R8: lw (op 100011) loads rt from address rs + sign-extended offset. sw (op 101011) stores rt there. A store writes no register.
- R9: beq (op 000100) and bne (op 000101) compare rs with rt. When equal or unequal respectively, they move the PC to PC+4 + (sign-extended imm << 2). Otherwise the PC advances to PC+4.
- R10: j (op 000010) moves the PC to {PC+4[31:28], addr26, 2'b00}. jal (op 000011) does the same and also writes PC+4 to register 31.
- R11: jr (funct 001000) loads the PC from rs and writes no register.
- R12: Every other instruction advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 32 | Byte address of the instruction being fetched (current PC) |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data (rt value) |
| dmem_we | output | 1 | Store strobe, write at the next rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |

## Verification
The bench builds the core with its defaults: a reset address of zero and two synchronizer stages. Because the reset address is zero, every absolute jump lands in the lowest 256 MB segment, so the upper four PC bits stay zero throughout. The two-stage release means the first fetch occurs a few cycles after reset is deasserted. The bench therefore finds the first address step rather than assuming a fixed cycle, and that lets it check sequential PC advance directly. Short stored programs cover forward and backward branches, a call and return through register 31, negative load/store offsets, and sign or zero extension at the 16-bit boundary. Each program ends in a branch-to-self and leaves its results in bench memory.

// File: rtl/tri_core_pkg.sv
package tri_core_pkg;

  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int JADR_W = 26;
  localparam int RIDX_W = 5;
  localparam int SH_W   = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JAL   = 6'b000011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_SLTI  = 6'b001010;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {IMM_SIGN, IMM_ZERO, IMM_UPPER} imm_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_e;
  typedef enum logic [1:0] {NXT_SEQ, NXT_BRANCH, NXT_ABS, NXT_REG} nxt_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    b_imm;
    imm_e    imm_kind;
    logic    rf_we;
    wb_e     wb_sel;
    dst_e    dst;
    logic    mem_we;
    nxt_e    nxt;
    logic    br_on_ne;
  } ctl_t;

endpackage

// File: rtl/core_decoder.sv
module core_decoder
  import tri_core_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctl_t       ctl
);

  always_comb begin
    ctl.alu_op   = ALU_ADD;
    ctl.b_imm    = 1'b0;
    ctl.imm_kind = IMM_SIGN;
    ctl.rf_we    = 1'b0;
    ctl.wb_sel   = WB_ALU;
    ctl.dst      = DST_RD;
    ctl.mem_we   = 1'b0;
    ctl.nxt      = NXT_SEQ;
    ctl.br_on_ne = 1'b0;
    case (op)
      OP_RTYPE: begin
        ctl.rf_we = 1'b1;
        case (funct)
          FN_ADD: ctl.alu_op = ALU_ADD;
          FN_SUB: ctl.alu_op = ALU_SUB;
          FN_AND: ctl.alu_op = ALU_AND;
          FN_OR:  ctl.alu_op = ALU_OR;
          FN_NOR: ctl.alu_op = ALU_NOR;
          FN_SLT: ctl.alu_op = ALU_SLT;
          FN_SLL: ctl.alu_op = ALU_SLL;
          FN_SRL: ctl.alu_op = ALU_SRL;
          FN_JR: begin
            ctl.rf_we = 1'b0;
            ctl.nxt   = NXT_REG;
          end
          default: ctl.rf_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctl.rf_we = 1'b1;
        ctl.b_imm = 1'b1;
        ctl.dst   = DST_RT;
      end
      OP_SLTI: begin
        ctl.rf_we  = 1'b1;
        ctl.b_imm  = 1'b1;
        ctl.dst    = DST_RT;
        ctl.alu_op = ALU_SLT;
      end
      OP_ORI: begin
        ctl.rf_we    = 1'b1;
        ctl.b_imm    = 1'b1;
        ctl.dst      = DST_RT;
        ctl.alu_op   = ALU_OR;
        ctl.imm_kind = IMM_ZERO;
      end
      OP_LUI: begin
        ctl.rf_we    = 1'b1;
        ctl.b_imm    = 1'b1;
        ctl.dst      = DST_RT;
        ctl.alu_op   = ALU_PASSB;
        ctl.imm_kind = IMM_UPPER;
      end
      OP_LW: begin
        ctl.rf_we  = 1'b1;
        ctl.b_imm  = 1'b1;
        ctl.dst    = DST_RT;
        ctl.wb_sel = WB_MEM;
      end
      OP_SW: begin
        ctl.b_imm  = 1'b1;
        ctl.mem_we = 1'b1;
      end
      OP_BEQ: ctl.nxt = NXT_BRANCH;
      OP_BNE: begin
        ctl.nxt      = NXT_BRANCH;
        ctl.br_on_ne = 1'b1;
      end
      OP_J: ctl.nxt = NXT_ABS;
      OP_JAL: begin
        ctl.nxt    = NXT_ABS;
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = WB_LINK;
        ctl.dst    = DST_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import tri_core_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_B = 5
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_B-1:0] shamt,
  output logic [W-1:0]    y
);

  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_NOR:   y = ~(a | b);
      ALU_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL:   y = b << shamt;
      ALU_SRL:   y = b >> shamt;
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] slots [N];
  logic         wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) slots[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : slots[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : slots[raddr_b];

endmodule

// File: rtl/core_fetch.sv
module core_fetch
  import tri_core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nxt_e              nxt,
  input  logic              br_on_ne,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JADR_W-1:0] addr26,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   pc_plus4
);

  logic [XLEN-1:0] pc_q, pc_d, br_tgt, jmp_tgt;
  logic            br_hit;

  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {{(XLEN-IMM_W-2){imm16[IMM_W-1]}}, imm16, 2'b00};
  assign jmp_tgt  = {pc_plus4[XLEN-1:JADR_W+2], addr26, 2'b00};
  assign br_hit   = (rs_val == rt_val) ^ br_on_ne;

  always_comb begin
    case (nxt)
      NXT_BRANCH: pc_d = br_hit ? br_tgt : pc_plus4;
      NXT_ABS:    pc_d = jmp_tgt;
      NXT_REG:    pc_d = rs_val;
      default:    pc_d = pc_plus4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

  p_seq_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == NXT_SEQ) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  p_branch_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == NXT_BRANCH && !br_hit) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  p_reg_jump_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == NXT_REG) |=> (pc_q == $past(rs_val)));

  p_abs_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == NXT_ABS) |=> (pc_q[JADR_W+1:0] == {$past(addr26), 2'b00}));

endmodule

// File: rtl/tri_fmt_core.sv
module tri_fmt_core
  import tri_core_pkg::*;
#(
  parameter logic [31:0] RESET_PC    = 32'h0000_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);

  localparam int NREGS = 1 << RIDX_W;

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  // instruction fields
  logic [5:0]        f_op, f_funct;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
  logic [SH_W-1:0]   f_shamt;
  logic [IMM_W-1:0]  f_imm;
  logic [JADR_W-1:0] f_addr;

  assign f_op    = imem_data[31:26];
  assign f_rs    = imem_data[25:21];
  assign f_rt    = imem_data[20:16];
  assign f_rd    = imem_data[15:11];
  assign f_shamt = imem_data[10:6];
  assign f_funct = imem_data[5:0];
  assign f_imm   = imem_data[15:0];
  assign f_addr  = imem_data[25:0];

  ctl_t              ctl;
  logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y;
  logic [XLEN-1:0]   rf_wdata, pc, pc_plus4;
  logic [RIDX_W-1:0] rf_waddr;
  logic              rf_we;

  core_decoder u_dec (
    .op    (f_op),
    .funct (f_funct),
    .ctl   (ctl)
  );

  always_comb begin
    case (ctl.imm_kind)
      IMM_ZERO:  imm_ext = {{(XLEN-IMM_W){1'b0}}, f_imm};
      IMM_UPPER: imm_ext = {f_imm, {(XLEN-IMM_W){1'b0}}};
      default:   imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    endcase
  end

  assign alu_b = ctl.b_imm ? imm_ext : rt_val;

  core_alu #(.W(XLEN), .SH_B(SH_W)) u_alu (
    .op    (ctl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (f_shamt),
    .y     (alu_y)
  );

  always_comb begin
    case (ctl.dst)
      DST_RT:   rf_waddr = f_rt;
      DST_LINK: rf_waddr = RIDX_W'(NREGS - 1);
      default:  rf_waddr = f_rd;
    endcase
    case (ctl.wb_sel)
      WB_MEM:  rf_wdata = dmem_rdata;
      WB_LINK: rf_wdata = pc_plus4;
      default: rf_wdata = alu_y;
    endcase
  end

  assign rf_we = ctl.rf_we && rst_core_n;

  core_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (f_rs),
    .rdata_a (rs_val),
    .raddr_b (f_rt),
    .rdata_b (rt_val)
  );

  core_fetch #(.RESET_PC(RESET_PC)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .nxt      (ctl.nxt),
    .br_on_ne (ctl.br_on_ne),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .imm16    (f_imm),
    .addr26   (f_addr),
    .pc       (pc),
    .pc_plus4 (pc_plus4)
  );

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we && rst_core_n;

  p_store_quiet_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    dmem_we |-> !rf_we);

  p_slt_bool_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctl.alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));

  p_link_dst_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctl.wb_sel == WB_LINK) |-> (rf_we && rf_waddr == RIDX_W'(NREGS - 1)));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_core_n |-> (!dmem_we && !rf_we));

endmodule

// File: tb/tri_fmt_core_test.sv
module tri_fmt_core_test;

  localparam logic [5:0] OP_J = 6'b000010, OP_JAL = 6'b000011, OP_BEQ = 6'b000100,
                         OP_BNE = 6'b000101, OP_ADDI = 6'b001000, OP_SLTI = 6'b001010,
                         OP_ORI = 6'b001101, OP_LUI = 6'b001111, OP_LW = 6'b100011,
                         OP_SW = 6'b101011;
  localparam logic [5:0] FN_SLL = 6'b000000, FN_SRL = 6'b000010, FN_JR = 6'b001000,
                         FN_ADD = 6'b100000, FN_SUB = 6'b100010, FN_AND = 6'b100100,
                         FN_OR = 6'b100101, FN_NOR = 6'b100111, FN_SLT = 6'b101010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tri_fmt_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt,
                                        input int rd, input int sh);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input int word_idx);
    return {op, 26'(word_idx)};
  endfunction

  function automatic logic [31:0] halt();
    return enc_i(OP_BEQ, 0, 0, -1);
  endfunction

  function automatic logic [31:0] mem_at(input int byte_addr);
    return dmem[byte_addr >> 2];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_run(input int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "fetch address in reset", imem_addr, 32'h0);
    check("R1", "store strobe in reset", {31'b0, dmem_we}, 32'h0);
  endtask

  task automatic t_arith();
    logic [31:0] trace [8];
    int first;
    hold_reset();
    imem[0] = enc_i(OP_ADDI, 0, 1, 100);
    imem[1] = enc_i(OP_ADDI, 0, 2, -7);
    imem[2] = enc_r(FN_ADD, 1, 2, 3, 0);
    imem[3] = enc_r(FN_SUB, 2, 1, 4, 0);
    imem[4] = enc_i(OP_ADDI, 0, 0, 55);
    imem[5] = enc_r(FN_ADD, 0, 0, 5, 0);
    imem[6] = enc_i(OP_SW, 0, 3, 'h00);
    imem[7] = enc_i(OP_SW, 0, 4, 'h04);
    imem[8] = enc_i(OP_SW, 0, 5, 'h08);
    imem[9] = halt();
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      trace[k] = imem_addr;
      @(negedge clk);
    end
    first = -1;
    for (int k = 0; k < 8; k++) if (first < 0 && trace[k] != 32'h0) first = k;
    check("R1", "first fetch address after release", trace[0], 32'h0);
    if (first < 1 || first > 5) begin
      check("R12", "PC leaves reset address", 32'(first), 32'd3);
    end else begin
      check("R12", "step 1", trace[first], 32'h4);
      check("R12", "step 2", trace[first + 1], 32'h8);
      check("R12", "step 3", trace[first + 2], 32'hC);
    end
    repeat (40) @(negedge clk);
    check("R2", "add 100 + -7", mem_at('h00), 32'd93);
    check("R2", "sub -7 - 100", mem_at('h04), 32'hFFFF_FF95);
    check("R7", "r0 after write attempt", mem_at('h08), 32'h0);
  endtask

  task automatic t_logic();
    logic [31:0] a, b;
    hold_reset();
    imem[0]  = enc_i(OP_LUI, 0, 1, 'h00FF);
    imem[1]  = enc_i(OP_ORI, 1, 1, 'h0F0F);
    imem[2]  = enc_i(OP_ADDI, 0, 2, 'h03C0);
    imem[3]  = enc_r(FN_AND, 1, 2, 3, 0);
    imem[4]  = enc_r(FN_OR, 1, 2, 4, 0);
    imem[5]  = enc_r(FN_NOR, 1, 2, 5, 0);
    imem[6]  = enc_i(OP_SW, 0, 3, 'h40);
    imem[7]  = enc_i(OP_SW, 0, 4, 'h44);
    imem[8]  = enc_i(OP_SW, 0, 5, 'h48);
    imem[9]  = enc_i(OP_LUI, 0, 6, 'h8001);
    imem[10] = enc_i(OP_ORI, 6, 6, 'hFFFF);
    imem[11] = enc_i(OP_ADDI, 0, 7, 'hFFFF);
    imem[12] = enc_i(OP_LUI, 0, 8, 'h1234);
    imem[13] = enc_i(OP_SW, 0, 6, 'h4C);
    imem[14] = enc_i(OP_SW, 0, 7, 'h50);
    imem[15] = enc_i(OP_SW, 0, 8, 'h54);
    imem[16] = halt();
    release_run(60);
    a = 32'h00FF_0F0F;
    b = 32'h0000_03C0;
    check("R3", "and", mem_at('h40), a & b);
    check("R3", "or", mem_at('h44), a | b);
    check("R3", "nor", mem_at('h48), ~(a | b));
    check("R6", "lui+ori zero-extends", mem_at('h4C), 32'h8001_FFFF);
    check("R6", "addi sign-extends", mem_at('h50), 32'hFFFF_FFFF);
    check("R6", "lui clears low half", mem_at('h54), 32'h1234_0000);
  endtask

  task automatic t_shift();
    hold_reset();
    imem[0] = enc_i(OP_LUI, 0, 1, 'h8000);
    imem[1] = enc_i(OP_ORI, 1, 1, 'h0011);
    imem[2] = enc_r(FN_SLL, 0, 1, 2, 4);
    imem[3] = enc_r(FN_SRL, 0, 1, 3, 4);
    imem[4] = enc_r(FN_SRL, 0, 1, 4, 31);
    imem[5] = enc_i(OP_SW, 0, 2, 'h60);
    imem[6] = enc_i(OP_SW, 0, 3, 'h64);
    imem[7] = enc_i(OP_SW, 0, 4, 'h68);
    imem[8] = halt();
    release_run(40);
    check("R4", "sll by 4", mem_at('h60), 32'h0000_0110);
    check("R4", "srl by 4 zero fill", mem_at('h64), 32'h0800_0001);
    check("R4", "srl by 31", mem_at('h68), 32'h0000_0001);
  endtask

  task automatic t_compare();
    hold_reset();
    imem[0]  = enc_i(OP_ADDI, 0, 1, -5);
    imem[1]  = enc_i(OP_ADDI, 0, 2, 3);
    imem[2]  = enc_r(FN_SLT, 1, 2, 3, 0);
    imem[3]  = enc_r(FN_SLT, 2, 1, 4, 0);
    imem[4]  = enc_i(OP_SLTI, 1, 5, -4);
    imem[5]  = enc_i(OP_SLTI, 2, 6, 3);
    imem[6]  = enc_r(FN_SLT, 1, 1, 7, 0);
    imem[7]  = enc_i(OP_SW, 0, 3, 'hA0);
    imem[8]  = enc_i(OP_SW, 0, 4, 'hA4);
    imem[9]  = enc_i(OP_SW, 0, 5, 'hA8);
    imem[10] = enc_i(OP_SW, 0, 6, 'hAC);
    imem[11] = enc_i(OP_SW, 0, 7, 'hB0);
    imem[12] = halt();
    release_run(50);
    check("R5", "slt -5 < 3", mem_at('hA0), 32'd1);
    check("R5", "slt 3 < -5", mem_at('hA4), 32'd0);
    check("R5", "slti -5 < -4", mem_at('hA8), 32'd1);
    check("R5", "slti 3 < 3", mem_at('hAC), 32'd0);
    check("R5", "slt equal", mem_at('hB0), 32'd0);
  endtask

  task automatic t_memory();
    hold_reset();
    imem[0] = enc_i(OP_ADDI, 0, 1, 'h200);
    imem[1] = enc_i(OP_ADDI, 0, 2, 'h1234);
    imem[2] = enc_i(OP_SW, 1, 2, -8);
    imem[3] = enc_i(OP_LW, 1, 3, -8);
    imem[4] = enc_i(OP_ADDI, 3, 3, 1);
    imem[5] = enc_i(OP_SW, 1, 3, 16);
    imem[6] = enc_i(OP_LW, 1, 0, -8);
    imem[7] = enc_i(OP_SW, 1, 0, 20);
    imem[8] = halt();
    release_run(40);
    check("R8", "store at negative offset", mem_at('h1F8), 32'h0000_1234);
    check("R8", "load then store", mem_at('h210), 32'h0000_1235);
    check("R7", "load into r0 discarded", mem_at('h214), 32'h0);
  endtask

  task automatic t_branch();
    hold_reset();
    imem[0]  = enc_i(OP_SW, 0, 0, 'h80);
    imem[1]  = enc_i(OP_ADDI, 0, 1, 7);
    imem[2]  = enc_i(OP_ADDI, 0, 2, 7);
    imem[3]  = enc_i(OP_BEQ, 1, 2, 1);
    imem[4]  = enc_i(OP_SW, 0, 1, 'h80);
    imem[5]  = enc_i(OP_BNE, 1, 2, 1);
    imem[6]  = enc_i(OP_ADDI, 0, 4, 9);
    imem[7]  = enc_i(OP_BNE, 1, 0, 1);
    imem[8]  = enc_i(OP_ADDI, 0, 4, 'h77);
    imem[9]  = enc_i(OP_SW, 0, 4, 'h88);
    imem[10] = enc_i(OP_ADDI, 0, 5, 3);
    imem[11] = enc_i(OP_ADDI, 0, 6, 0);
    imem[12] = enc_i(OP_ADDI, 6, 6, 2);
    imem[13] = enc_i(OP_ADDI, 5, 5, -1);
    imem[14] = enc_i(OP_BNE, 5, 0, -3);
    imem[15] = enc_i(OP_SW, 0, 6, 'h8C);
    imem[16] = halt();
    release_run(80);
    check("R9", "taken beq skips store", mem_at('h80), 32'h0);
    check("R9", "untaken bne then taken bne", mem_at('h88), 32'd9);
    check("R9", "backward loop three passes", mem_at('h8C), 32'd6);
  endtask

  task automatic t_jump();
    hold_reset();
    imem[0] = enc_i(OP_ADDI, 0, 1, 1);
    imem[1] = enc_j(OP_J, 3);
    imem[2] = enc_i(OP_ADDI, 0, 1, 'h55);
    imem[3] = enc_i(OP_SW, 0, 1, 'hC0);
    imem[4] = enc_j(OP_JAL, 8);
    imem[5] = enc_i(OP_SW, 0, 31, 'hC4);
    imem[6] = enc_i(OP_SW, 0, 2, 'hC8);
    imem[7] = halt();
    imem[8] = enc_i(OP_ADDI, 0, 2, 'h66);
    imem[9] = enc_r(FN_JR, 31, 0, 0, 0);
    release_run(50);
    check("R10", "j skips one word", mem_at('hC0), 32'd1);
    check("R10", "jal link value", mem_at('hC4), 32'h0000_0014);
    check("R11", "jr returns after callee", mem_at('hC8), 32'h0000_0066);
    check("R11", "parked at halt word", imem_addr, 32'h0000_001C);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_compare();
    t_memory();
    t_branch();
    t_jump();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule